// File: doc/BRIEF.md
# Control-Transfer Resolution Unit

This unit decides, in a single combinational pass, what a 32-bit integer core fetches after a control-transfer instruction. It takes the current program counter, the instruction word and the two source operand values. It returns whether control leaves the sequential path, the address to fetch next, the return address for the link register and its write enable, an exception flag for a misaligned target, and a flag for a branch with an undefined condition code.

The unit handles the six conditional branches, the PC-relative jump-and-link and the register-indirect jump-and-link. It rebuilds their immediates from the scattered instruction bits and forms each target with its own adder. Fetch sequencing, the register file, writeback selection, trap entry and prediction belong to neighbouring blocks.

Top module: `cti_resolve`

## Requirements
- R1: For a branch (opcode bits 6:0 = 1100011) the target is pc plus the sign-extension of {insn[31], insn[7], insn[30:25], insn[11:8], 0}, so offsets are even and span -4096 to +4094 bytes.
- R2: For a direct jump (opcode 1101111) the target is pc plus the sign-extension of {insn[31], insn[19:12], insn[20], insn[30:21], 0}, spanning -1 MiB to +1 MiB - 2.
- R3: For an indirect jump (opcode 1100111) the target is src1 plus the sign-extension of insn[31:20], unscaled, with bit 0 of the sum cleared.
- R4: A branch is taken according to insn[14:12]: 000 equal, 001 not equal, 100 signed less-than, 101 signed greater-or-equal, 110 unsigned less-than, 111 unsigned greater-or-equal, always comparing src1 against src2.
- R5: Both jump forms are always taken; the link value is pc+4, and the link write enable is high only when rd (insn[11:7]) is not zero.
- R6: The misaligned flag is raised exactly when the transfer is taken and bits 1:0 of its target are not both zero; a branch that is not taken never raises it.
- R7: When no transfer is taken, next_pc is pc+4; when one is taken, next_pc is its target, including when the misaligned flag is raised.
- R8: A branch with insn[14:12] equal to 010 or 011 raises the illegal flag and is not taken.
- R9: Any other opcode gives no transfer, no link write, no illegal flag and no misaligned flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_i | input | 32 | Address of the instruction being resolved |
| insn_i | input | 32 | Instruction word |
| src1_i | input | 32 | First source operand value |
| src2_i | input | 32 | Second source operand value |
| taken_o | output | 1 | Control leaves the sequential path |
| next_pc_o | output | 32 | Address to fetch next |
| link_we_o | output | 1 | Write the link value to rd |
| link_val_o | output | 32 | Return address, pc+4 |
| misalign_o | output | 1 | Taken target not aligned to 4 bytes |
| illegal_o | output | 1 | Branch with an undefined condition code |

## Verification
Every output is a pure function of the current inputs, so each result is due in the same cycle its stimulus is applied, with no register in between. The bench drives a new instruction and operands just after a rising clock edge and compares all six outputs at the following falling edge, half a period later, when the paths have settled and before the next stimulus arrives. Random vectors with forced control opcodes are mixed with directed ones at the extreme offsets, the relocated bit 7, odd indirect sums, rd of zero and the unused condition codes.

// File: rtl/cti_resolve.sv
module cti_resolve #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [31:0]     insn_i,
  input  logic [XLEN-1:0] src1_i,
  input  logic [XLEN-1:0] src2_i,
  output logic            taken_o,
  output logic [XLEN-1:0] next_pc_o,
  output logic            link_we_o,
  output logic [XLEN-1:0] link_val_o,
  output logic            misalign_o,
  output logic            illegal_o
);
  localparam logic [6:0] OP_BR   = 7'b1100011;
  localparam logic [6:0] OP_JAL  = 7'b1101111;
  localparam logic [6:0] OP_JALR = 7'b1100111;
  localparam int         ALIGN_BITS = 2;
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [6:0]      opc;
  logic [2:0]      cond;
  logic [4:0]      rd;
  logic            is_br, is_jal, is_jalr;
  logic [XLEN-1:0] imm_b, imm_j, imm_i;
  logic [XLEN-1:0] seq_pc, ind_sum, target;
  logic            eq, lt_s, lt_u, cond_ok, cond_bad;

  assign opc  = insn_i[6:0];
  assign cond = insn_i[14:12];
  assign rd   = insn_i[11:7];

  assign is_br   = (opc == OP_BR);
  assign is_jal  = (opc == OP_JAL);
  assign is_jalr = (opc == OP_JALR);

  assign imm_b = {{(XLEN-12){insn_i[31]}}, insn_i[7], insn_i[30:25], insn_i[11:8], 1'b0};
  assign imm_j = {{(XLEN-20){insn_i[31]}}, insn_i[19:12], insn_i[20], insn_i[30:21], 1'b0};
  assign imm_i = {{(XLEN-11){insn_i[31]}}, insn_i[30:20]};

  assign eq   = (src1_i == src2_i);
  assign lt_s = ($signed(src1_i) < $signed(src2_i));
  assign lt_u = (src1_i < src2_i);

  always_comb begin
    cond_ok  = 1'b0;
    cond_bad = 1'b0;
    case (cond)
      3'b000:  cond_ok = eq;
      3'b001:  cond_ok = !eq;
      3'b100:  cond_ok = lt_s;
      3'b101:  cond_ok = !lt_s;
      3'b110:  cond_ok = lt_u;
      3'b111:  cond_ok = !lt_u;
      default: cond_bad = 1'b1;
    endcase
  end

  assign seq_pc  = pc_i + STEP;
  assign ind_sum = src1_i + imm_i;

  always_comb begin
    if (is_jalr)     target = {ind_sum[XLEN-1:1], 1'b0};
    else if (is_jal) target = pc_i + imm_j;
    else             target = pc_i + imm_b;
  end

  assign illegal_o  = is_br & cond_bad;
  assign taken_o    = is_jal | is_jalr | (is_br & cond_ok & !cond_bad);
  assign misalign_o = taken_o & (|target[ALIGN_BITS-1:0]);
  assign next_pc_o  = taken_o ? target : seq_pc;
  assign link_val_o = seq_pc;
  assign link_we_o  = (is_jal | is_jalr) & (rd != 5'd0);
endmodule

// File: rtl/cti_resolve_checks.sv
module cti_resolve_checks #(
  parameter int XLEN = 32
) (
  input logic [XLEN-1:0] pc_i,
  input logic [31:0]     insn_i,
  input logic            taken_o,
  input logic [XLEN-1:0] next_pc_o,
  input logic            link_we_o,
  input logic            misalign_o,
  input logic            illegal_o
);
  always_comb begin
    if (misalign_o)
      a_r6_flag_needs_taken: assert (taken_o);
    if (!taken_o)
      a_r7_sequential_next: assert (next_pc_o == pc_i + XLEN'(4));
    if (insn_i[6:0] == 7'b1100111)
      a_r3_indirect_even: assert (next_pc_o[0] == 1'b0);
    if (illegal_o)
      a_r8_bad_cond_idle: assert (!taken_o && !link_we_o);
    if (link_we_o)
      a_r5_link_only_on_jump: assert (taken_o && insn_i[11:7] != 5'd0);
  end
endmodule

bind cti_resolve cti_resolve_checks #(.XLEN(XLEN)) u_checks (
  .pc_i(pc_i), .insn_i(insn_i), .taken_o(taken_o), .next_pc_o(next_pc_o),
  .link_we_o(link_we_o), .misalign_o(misalign_o), .illegal_o(illegal_o)
);

// File: tb/cti_resolve_test.sv
module cti_resolve_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] pc_i, insn_i, src1_i, src2_i;
  logic        taken_o, link_we_o, misalign_o, illegal_o;
  logic [31:0] next_pc_o, link_val_o;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  cti_resolve uut (
    .pc_i(pc_i), .insn_i(insn_i), .src1_i(src1_i), .src2_i(src2_i),
    .taken_o(taken_o), .next_pc_o(next_pc_o), .link_we_o(link_we_o),
    .link_val_o(link_val_o), .misalign_o(misalign_o), .illegal_o(illegal_o)
  );

  function automatic logic [31:0] enc_br(input logic [12:0] off, input logic [2:0] f3);
    return {off[12], off[10:5], 5'd2, 5'd1, f3, off[4:1], off[11], 7'h63};
  endfunction

  function automatic logic [31:0] enc_jal(input logic [20:0] off, input logic [4:0] rd);
    return {off[20], off[10:1], off[11], off[19:12], rd, 7'h6f};
  endfunction

  function automatic logic [31:0] enc_jalr(input logic [11:0] off, input logic [4:0] rd);
    return {off, 5'd1, 3'b000, rd, 7'h67};
  endfunction

  task automatic model(input logic [31:0] pc, ins, a, b,
                       output logic tk, output logic [31:0] nx, output logic we,
                       output logic [31:0] lk, output logic mis, output logic ill);
    logic [31:0] tgt;
    logic [12:0] ob;
    logic [20:0] oj;
    tk = 1'b0; we = 1'b0; ill = 1'b0; tgt = '0; lk = pc + 32'd4;
    case (ins[6:0])
      7'h63: begin
        ob  = {ins[31], ins[7], ins[30:25], ins[11:8], 1'b0};
        tgt = pc + {{19{ob[12]}}, ob};
        case (ins[14:12])
          3'd0: tk = (a == b);
          3'd1: tk = (a != b);
          3'd4: tk = ($signed(a) < $signed(b));
          3'd5: tk = ($signed(a) >= $signed(b));
          3'd6: tk = (a < b);
          3'd7: tk = (a >= b);
          default: ill = 1'b1;
        endcase
      end
      7'h6f: begin
        oj  = {ins[31], ins[19:12], ins[20], ins[30:21], 1'b0};
        tgt = pc + {{11{oj[20]}}, oj};
        tk = 1'b1; we = (ins[11:7] != 0);
      end
      7'h67: begin
        tgt = a + {{20{ins[31]}}, ins[31:20]};
        tgt[0] = 1'b0;
        tk = 1'b1; we = (ins[11:7] != 0);
      end
      default: ;
    endcase
    mis = tk && (tgt[1:0] != 2'b00);
    nx  = tk ? tgt : pc + 32'd4;
  endtask

  task automatic cmp(input string tag, input string what, input logic [31:0] act, exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] pc, ins, a, b, input string tag);
    logic tk, we, mis, ill;
    logic [31:0] nx, lk;
    @(posedge clk);
    #1;
    pc_i = pc; insn_i = ins; src1_i = a; src2_i = b;
    @(negedge clk);
    model(pc, ins, a, b, tk, nx, we, lk, mis, ill);
    vectors++;
    cmp(tag, "taken", {31'd0, taken_o}, {31'd0, tk});
    cmp(tk ? tag : "R7", "next_pc", next_pc_o, nx);
    cmp("R5", "link_we", {31'd0, link_we_o}, {31'd0, we});
    if (we) cmp("R5", "link_val", link_val_o, lk);
    cmp("R6", "misalign", {31'd0, misalign_o}, {31'd0, mis});
    cmp("R8", "illegal", {31'd0, illegal_o}, {31'd0, ill});
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        miscompares++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] ins, a, b, pc;
    string tag;
    pc_i = 0; insn_i = 0; src1_i = 0; src2_i = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Reset state: zero instruction, no transfer (R9, R7)
    apply(32'h0000_0100, 32'h0, 32'h0, 32'h0, "R9");
    // R1 R4: most negative branch offset, equal operands
    apply(32'h0000_2000, enc_br(13'h1000, 3'b000), 32'd5, 32'd5, "R1");
    // R1: offset bit 11 comes from insn bit 7
    apply(32'h0000_2000, enc_br(13'h0800, 3'b001), 32'd1, 32'd2, "R1");
    // R1: largest positive offset
    apply(32'h0001_0000, enc_br(13'h0ffe, 3'b111), 32'd9, 32'd3, "R1");
    // R6: not-taken branch to misaligned target, no flag
    apply(32'h0000_4000, enc_br(13'h0002, 3'b001), 32'd7, 32'd7, "R6");
    // R6: taken branch to misaligned target raises flag, R7 keeps target
    apply(32'h0000_4000, enc_br(13'h0002, 3'b000), 32'd7, 32'd7, "R6");
    // R4: signed versus unsigned with negative operand
    apply(32'h0000_0800, enc_br(13'h0010, 3'b100), 32'hffff_fff0, 32'd1, "R4");
    apply(32'h0000_0800, enc_br(13'h0010, 3'b110), 32'hffff_fff0, 32'd1, "R4");
    apply(32'h0000_0800, enc_br(13'h0010, 3'b101), 32'd1, 32'hffff_fff0, "R4");
    apply(32'h0000_0800, enc_br(13'h0010, 3'b111), 32'd1, 32'hffff_fff0, "R4");
    // R8: unused condition codes
    apply(32'h0000_0800, enc_br(13'h0010, 3'b010), 32'd3, 32'd3, "R8");
    apply(32'h0000_0800, enc_br(13'h0010, 3'b011), 32'd3, 32'd4, "R8");
    // R2: most negative jump offset, rd zero discards link (R5)
    apply(32'h0020_0000, enc_jal(21'h10_0000, 5'd0), 32'd0, 32'd0, "R2");
    // R2: positive jump with rd=x1
    apply(32'h0000_1000, enc_jal(21'h0_0ffc, 5'd1), 32'd0, 32'd0, "R2");
    // R3: odd sum has bit 0 cleared, aligned otherwise
    apply(32'h0000_3000, enc_jalr(12'h001, 5'd5), 32'h0000_8000, 32'd0, "R3");
    // R3: negative unscaled offset gives misaligned target (R6)
    apply(32'h0000_3000, enc_jalr(12'hfff, 5'd1), 32'h0000_8000, 32'd0, "R3");
    // R9: arithmetic opcode leaves flow sequential
    apply(32'h0000_5000, 32'h0010_0093, 32'd1, 32'd1, "R9");

    for (int i = 0; i < 4000; i++) begin
      ins = $urandom;
      a   = $urandom;
      b   = ($urandom % 4 == 0) ? a : $urandom;
      pc  = ($urandom % 8 == 0) ? $urandom : ($urandom & 32'hffff_fffc);
      case ($urandom % 4)
        0: begin ins[6:0] = 7'h63; tag = "R1/R4"; end
        1: begin ins[6:0] = 7'h6f; tag = "R2"; end
        2: begin ins[6:0] = 7'h67; tag = "R3"; end
        default: tag = "R9";
      endcase
      apply(pc, ins, a, b, tag);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule